// File: doc/BRIEF.md
# Windowed Memory Address Translator

This block turns the two kinds of address a small processor core issues into physical locations. A 16-bit data address falls into one of three regions. The lower half goes straight to local data RAM. The top quarter also reaches local data RAM, except where it is treated as peripheral space. The quarter in between is a 16 KB window whose destination comes from a data map register. A word-granular fetch PC is turned into a byte address and translated through one of two fetch map registers, picked by the upper or lower half of the fetch space.

Each map register either points at a bank of instruction memory or names a 128 KB segment of a large unified memory. Only some unified segments exist. Their presence is fixed by a parameter bitmask, and any translation that lands in a missing segment raises an error flag. The three map registers are loaded through one write port. Both translations come out of output registers one clock after their inputs are presented.

Top module: `win_xlat`

## Requirements
- R1: A data address below 0x8000 gives target code 00 (local data RAM), a physical address equal to the data address, and no error.
- R2: A data address of 0xC000 or above gives a physical address equal to the data address and no error. The target code is 00 for 0xFF00 through 0xFF0F and 11 (peripheral space) for every other address in that range.
- R3: A data address from 0x8000 to 0xBFFF with data-map bit 12 set gives target code 01 (instruction memory) and physical address data-map[3:0] × 0x4000 + (address − 0x8000), with no error.
- R4: A data address from 0x8000 to 0xBFFF with data-map bit 12 clear gives target code 10 (unified memory) and physical address data-map[9:2] × 0x20000 + data-map[1:0] × 0x4000 + (address − 0x8000). The data error flag is set exactly when segment data-map[9:2] is absent.
- R5: The fetch byte address is PC × 4. The high fetch map is used when byte-address bit 17 is set, and the low fetch map otherwise. When the chosen map has bit 12 set, the target code is 01, the physical address is the byte address, and there is no error.
- R6: When the chosen fetch map has bit 12 clear, the target code is 10 and the physical address is map[7:0] × 0x20000 + (byte address mod 0x20000). The fetch error flag is set exactly when segment map[7:0] is absent.
- R7: While reset is held, every output is zero. After reset both fetch maps hold 0x1000 and the data map holds 0.
- R8: A map write with select 0 loads the data map, select 1 the low fetch map and select 2 the high fetch map. The new value applies to addresses presented from the next cycle on. Select 3 changes no map.
- R9: Each output reflects the inputs sampled at the previous rising clock edge and holds steady between edges.
- R10: With the default parameters, segments 0, 1, 2 and 127 are present and all others are absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_we | input | 1 | Map register write strobe |
| map_sel | input | 2 | Map select: 0 data map, 1 low fetch map, 2 high fetch map, 3 none |
| map_wdata | input | 16 | Value written to the selected map |
| d_addr | input | 16 | Data address to translate |
| pc | input | 16 | Word-granular fetch PC |
| d_tgt | output | 2 | Data target code (00 data RAM, 01 instruction, 10 unified, 11 peripheral) |
| d_phys | output | 25 | Data physical address |
| d_err | output | 1 | Data access to an absent unified segment |
| i_tgt | output | 2 | Fetch target code |
| i_phys | output | 25 | Fetch physical address |
| i_err | output | 1 | Fetch from an absent unified segment |

## Verification
The only state in this block is the three map registers and the output registers. A wrong map value shows up in the very next translation that uses it: a changed target code, shifted bank or segment bits in the physical address, or a flipped error flag. A bad fetch map shows up only in the half of the fetch space it covers. A data map fault hides until an address in the 0x8000–0xBFFF window is presented, so every map setting is followed by a sweep through that window and through both fetch halves. Each result is compared one edge after its inputs.

// File: rtl/win_xlat_pkg.sv
package win_xlat_pkg;

  localparam int DA_W         = 16;
  localparam int MAP_W        = 16;
  localparam int MAP_IMEM_BIT = 12;
  localparam logic [11:0] IO_EXEMPT_PAGE = 12'hFF0;

  localparam logic [MAP_W-1:0] DMAP_RESET = 16'h0000;
  localparam logic [MAP_W-1:0] IMAP_RESET = 16'h1000;

  typedef enum logic [1:0] {
    TGT_DMEM = 2'b00,
    TGT_IMEM = 2'b01,
    TGT_UMEM = 2'b10,
    TGT_IO   = 2'b11
  } tgt_e;

  typedef enum logic [1:0] {
    MSEL_DATA = 2'd0,
    MSEL_ILO  = 2'd1,
    MSEL_IHI  = 2'd2,
    MSEL_NONE = 2'd3
  } msel_e;

endpackage

// File: rtl/win_map_regs.sv
module win_map_regs
  import win_xlat_pkg::*;
#(
  parameter int W = MAP_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [1:0]   sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dmap,
  output logic [W-1:0] imap_lo,
  output logic [W-1:0] imap_hi
);

  localparam int NREG = 3;

  logic [NREG*W-1:0] flat;

  for (genvar g = 0; g < NREG; g++) begin : g_map
    localparam logic [W-1:0] RST_VAL = (g == 0) ? W'(DMAP_RESET) : W'(IMAP_RESET);
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= RST_VAL;
      else if (we && sel == 2'(g))
        q <= wdata;
    end
    assign flat[g*W +: W] = q;
  end

  assign dmap    = flat[0*W +: W];
  assign imap_lo = flat[1*W +: W];
  assign imap_hi = flat[2*W +: W];

endmodule

// File: rtl/win_data_xlat.sv
module win_data_xlat
  import win_xlat_pkg::*;
#(
  parameter int SEG_W      = 8,
  parameter int SEG_SPAN_W = 17,
  parameter int WIN_W      = 14,
  parameter int IBYTE_W    = 18,
  parameter logic [(1<<SEG_W)-1:0] PRESENT_MASK = '1
) (
  input  logic [DA_W-1:0]             addr,
  input  logic [MAP_W-1:0]            dmap,
  output logic [1:0]                  tgt,
  output logic [SEG_W+SEG_SPAN_W-1:0] phys,
  output logic                        err
);

  localparam int PA_W   = SEG_W + SEG_SPAN_W;
  localparam int BANK_W = IBYTE_W - WIN_W;
  localparam int SUB_W  = SEG_SPAN_W - 1 - WIN_W;

  logic [WIN_W-1:0] win_off;
  logic [SEG_W-1:0] seg;
  logic [1:0]       region;
  logic             unused_dmap_bits;

  assign win_off = addr[WIN_W-1:0];
  assign seg     = dmap[SUB_W +: SEG_W];
  assign region  = addr[DA_W-1 -: 2];
  assign unused_dmap_bits = ^{dmap[MAP_W-1:MAP_IMEM_BIT+1], dmap[MAP_IMEM_BIT-1:SUB_W+SEG_W]};

  always_comb begin
    tgt  = TGT_DMEM;
    phys = PA_W'(addr);
    err  = 1'b0;
    unique case (region)
      2'b00, 2'b01: begin
        tgt = TGT_DMEM;
      end
      2'b10: begin
        if (dmap[MAP_IMEM_BIT]) begin
          tgt  = TGT_IMEM;
          phys = PA_W'({dmap[BANK_W-1:0], win_off});
        end else begin
          tgt  = TGT_UMEM;
          phys = {seg, 1'b0, dmap[SUB_W-1:0], win_off};
          err  = !PRESENT_MASK[seg];
        end
      end
      default: begin
        tgt = (addr[DA_W-1:4] == IO_EXEMPT_PAGE) ? TGT_DMEM : TGT_IO;
      end
    endcase
  end

endmodule

// File: rtl/win_inst_xlat.sv
module win_inst_xlat
  import win_xlat_pkg::*;
#(
  parameter int PC_W       = 16,
  parameter int SEG_W      = 8,
  parameter int SEG_SPAN_W = 17,
  parameter logic [(1<<SEG_W)-1:0] PRESENT_MASK = '1
) (
  input  logic [PC_W-1:0]             pc,
  input  logic [MAP_W-1:0]            imap_lo,
  input  logic [MAP_W-1:0]            imap_hi,
  output logic [1:0]                  tgt,
  output logic [SEG_W+SEG_SPAN_W-1:0] phys,
  output logic                        err
);

  localparam int PA_W    = SEG_W + SEG_SPAN_W;
  localparam int IBYTE_W = PC_W + 2;

  logic [IBYTE_W-1:0] byte_addr;
  logic [MAP_W-1:0]   imap;
  logic [SEG_W-1:0]   seg;
  logic               unused_imap_bits;

  assign byte_addr = {pc, 2'b00};
  assign imap      = byte_addr[SEG_SPAN_W] ? imap_hi : imap_lo;
  assign seg       = imap[SEG_W-1:0];
  assign unused_imap_bits = ^{imap[MAP_W-1:MAP_IMEM_BIT+1], imap[MAP_IMEM_BIT-1:SEG_W]};

  always_comb begin
    if (imap[MAP_IMEM_BIT]) begin
      tgt  = TGT_IMEM;
      phys = PA_W'(byte_addr);
      err  = 1'b0;
    end else begin
      tgt  = TGT_UMEM;
      phys = {seg, byte_addr[SEG_SPAN_W-1:0]};
      err  = !PRESENT_MASK[seg];
    end
  end

endmodule

// File: rtl/win_xlat.sv
module win_xlat
  import win_xlat_pkg::*;
#(
  parameter int PC_W       = 16,
  parameter int SEG_W      = 8,
  parameter int SEG_SPAN_W = 17,
  parameter int WIN_W      = 14,
  parameter logic [(1<<SEG_W)-1:0] PRESENT_MASK =
    ((1<<SEG_W)'(1) << 127) | (1<<SEG_W)'(7)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        map_we,
  input  logic [1:0]                  map_sel,
  input  logic [MAP_W-1:0]            map_wdata,
  input  logic [DA_W-1:0]             d_addr,
  input  logic [PC_W-1:0]             pc,
  output logic [1:0]                  d_tgt,
  output logic [SEG_W+SEG_SPAN_W-1:0] d_phys,
  output logic                        d_err,
  output logic [1:0]                  i_tgt,
  output logic [SEG_W+SEG_SPAN_W-1:0] i_phys,
  output logic                        i_err
);

  localparam int PA_W    = SEG_W + SEG_SPAN_W;
  localparam int IBYTE_W = PC_W + 2;

  logic [MAP_W-1:0] dmap, imap_lo, imap_hi;
  logic [1:0]       d_tgt_c, i_tgt_c;
  logic [PA_W-1:0]  d_phys_c, i_phys_c;
  logic             d_err_c, i_err_c;

  win_map_regs #(.W(MAP_W)) u_maps (
    .clk     (clk),
    .rst     (rst),
    .we      (map_we),
    .sel     (map_sel),
    .wdata   (map_wdata),
    .dmap    (dmap),
    .imap_lo (imap_lo),
    .imap_hi (imap_hi)
  );

  win_data_xlat #(
    .SEG_W(SEG_W), .SEG_SPAN_W(SEG_SPAN_W), .WIN_W(WIN_W),
    .IBYTE_W(IBYTE_W), .PRESENT_MASK(PRESENT_MASK)
  ) u_dx (
    .addr (d_addr),
    .dmap (dmap),
    .tgt  (d_tgt_c),
    .phys (d_phys_c),
    .err  (d_err_c)
  );

  win_inst_xlat #(
    .PC_W(PC_W), .SEG_W(SEG_W), .SEG_SPAN_W(SEG_SPAN_W),
    .PRESENT_MASK(PRESENT_MASK)
  ) u_ix (
    .pc      (pc),
    .imap_lo (imap_lo),
    .imap_hi (imap_hi),
    .tgt     (i_tgt_c),
    .phys    (i_phys_c),
    .err     (i_err_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      d_tgt  <= '0;
      d_phys <= '0;
      d_err  <= 1'b0;
      i_tgt  <= '0;
      i_phys <= '0;
      i_err  <= 1'b0;
    end else begin
      d_tgt  <= d_tgt_c;
      d_phys <= d_phys_c;
      d_err  <= d_err_c;
      i_tgt  <= i_tgt_c;
      i_phys <= i_phys_c;
      i_err  <= i_err_c;
    end
  end

endmodule

// File: rtl/win_xlat_chk.sv
module win_xlat_chk #(
  parameter int DA_W = 16,
  parameter int PC_W = 16,
  parameter int PA_W = 25
) (
  input logic            clk,
  input logic            rst,
  input logic [DA_W-1:0] d_addr,
  input logic [PC_W-1:0] pc,
  input logic [1:0]      d_tgt,
  input logic [PA_W-1:0] d_phys,
  input logic            d_err,
  input logic [1:0]      i_tgt,
  input logic [PA_W-1:0] i_phys,
  input logic            i_err
);

  a_r1_low_direct: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(d_addr[DA_W-1])) |->
      (d_tgt == 2'b00 && d_phys == PA_W'($past(d_addr)) && !d_err));

  a_r2_high_passthru: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(d_addr[DA_W-1 -: 2]) == 2'b11) |->
      (d_tgt[1] == d_tgt[0] && d_phys == PA_W'($past(d_addr)) && !d_err));

  a_r4_derr_unified: assert property (@(posedge clk) disable iff (rst)
    d_err |-> d_tgt == 2'b10);

  a_r6_ierr_unified: assert property (@(posedge clk) disable iff (rst)
    i_err |-> i_tgt == 2'b10);

  a_r5_imem_fetch: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && i_tgt == 2'b01) |->
      (i_phys == PA_W'({$past(pc), 2'b00}) && !i_err));

  a_r7_reset_clear: assert property (@(posedge clk)
    rst |=> (d_tgt == 2'b00 && d_phys == '0 && !d_err &&
             i_tgt == 2'b00 && i_phys == '0 && !i_err));

endmodule

bind win_xlat win_xlat_chk #(.DA_W(win_xlat_pkg::DA_W), .PC_W(PC_W), .PA_W(PA_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .d_addr (d_addr),
  .pc     (pc),
  .d_tgt  (d_tgt),
  .d_phys (d_phys),
  .d_err  (d_err),
  .i_tgt  (i_tgt),
  .i_phys (i_phys),
  .i_err  (i_err)
);

// File: tb/win_xlat_tb.sv
module win_xlat_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        map_we = 1'b0;
  logic [1:0]  map_sel = 2'd0;
  logic [15:0] map_wdata = 16'h0;
  logic [15:0] d_addr = 16'h0;
  logic [15:0] pc = 16'h0;
  logic [1:0]  d_tgt, i_tgt;
  logic [24:0] d_phys, i_phys;
  logic        d_err, i_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [15:0] m_d  = 16'h0000;
  logic [15:0] m_lo = 16'h1000;
  logic [15:0] m_hi = 16'h1000;

  always #(CLK_PERIOD/2) clk = ~clk;

  win_xlat u_dut (
    .clk(clk), .rst(rst), .map_we(map_we), .map_sel(map_sel),
    .map_wdata(map_wdata), .d_addr(d_addr), .pc(pc),
    .d_tgt(d_tgt), .d_phys(d_phys), .d_err(d_err),
    .i_tgt(i_tgt), .i_phys(i_phys), .i_err(i_err)
  );

  // R10: default present segments
  function automatic bit seg_here(int s);
    return (s == 0) || (s == 1) || (s == 2) || (s == 127);
  endfunction

  function automatic logic [27:0] exp_d(logic [15:0] a, logic [15:0] dm);
    logic [1:0] t; int p; bit e; int s;
    e = 0; p = int'(a); t = 2'b00;
    if (a < 16'h8000) t = 2'b00;
    else if (a >= 16'hC000) t = (a >= 16'hFF00 && a <= 16'hFF0F) ? 2'b00 : 2'b11;
    else if (dm[12]) begin
      t = 2'b01;
      p = int'(dm[3:0]) * 32'h4000 + int'(a) - 32'h8000;
    end else begin
      t = 2'b10;
      s = int'(dm[9:2]);
      p = s * 32'h20000 + int'(dm[1:0]) * 32'h4000 + int'(a) - 32'h8000;
      e = !seg_here(s);
    end
    return {e, t, p[24:0]};
  endfunction

  function automatic logic [27:0] exp_i(logic [15:0] w, logic [15:0] lo, logic [15:0] hi);
    logic [1:0] t; int p; bit e; int b; logic [15:0] m; int s;
    b = int'(w) * 4;
    m = (b >= 32'h20000) ? hi : lo;
    e = 0;
    if (m[12]) begin
      t = 2'b01; p = b;
    end else begin
      t = 2'b10;
      s = int'(m[7:0]);
      p = s * 32'h20000 + (b % 32'h20000);
      e = !seg_here(s);
    end
    return {e, t, p[24:0]};
  endfunction

  function automatic string d_req(logic [15:0] a, logic [15:0] dm);
    if (a < 16'h8000) return "R1";
    if (a >= 16'hC000) return "R2";
    return dm[12] ? "R3" : "R4";
  endfunction

  task automatic cmp(string req, logic [27:0] act, logic [27:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual err=%0b tgt=%0d phys=0x%07h expected err=%0b tgt=%0d phys=0x%07h",
               req, act[27], act[26:25], act[24:0], exp[27], exp[26:25], exp[24:0]);
    end
  endtask

  // apply inputs, let one edge register them, compare both paths (R9)
  task automatic run_vec(logic [15:0] a, logic [15:0] w);
    d_addr = a; pc = w;
    @(posedge clk); #1;
    cmp(d_req(a, m_d), {d_err, d_tgt, d_phys}, exp_d(a, m_d));
    cmp(m_lo[12] && m_hi[12] ? "R5" : "R6", {i_err, i_tgt, i_phys}, exp_i(w, m_lo, m_hi));
  endtask

  // R8: map write
  task automatic wr_map(logic [1:0] s, logic [15:0] v);
    map_we = 1'b1; map_sel = s; map_wdata = v;
    @(posedge clk); #1;
    map_we = 1'b0;
    case (s)
      2'd0: m_d  = v;
      2'd1: m_lo = v;
      2'd2: m_hi = v;
      default: ;
    endcase
  endtask

  task automatic sweep_strided();
    logic [15:0] edges [10] = '{16'h0000, 16'h7FFF, 16'h8000, 16'h9ABC, 16'hBFFF,
                                16'hC000, 16'hFEFF, 16'hFF00, 16'hFF0F, 16'hFF10};
    for (int k = 0; k < 10; k++) run_vec(edges[k], edges[9-k]);
    run_vec(16'hFFFF, 16'h7FFF);
    run_vec(16'h8001, 16'h8000);
    for (int i = 0; i < 65536; i += 97) run_vec(16'(i), 16'(65535 - i));
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    d_addr = 16'h9000; pc = 16'hC000;
    repeat (3) @(posedge clk);
    #1;
    // R7: outputs cleared while reset is held
    cmp("R7", {d_err, d_tgt, d_phys, 1'b0, i_err, i_tgt, i_phys} == '0 ? 28'h0 : 28'h1, 28'h0);
    rst = 1'b0;

    // R7: reset map values, exhaustive data and fetch sweep
    for (int i = 0; i < 65536; i++) run_vec(16'(i), 16'(i));

    // R9: output holds between edges
    run_vec(16'h1234, 16'h0040);
    d_addr = 16'hFFFF; pc = 16'hFFFF; #2;
    cmp("R9", {d_err, d_tgt, d_phys}, exp_d(16'h1234, m_d));
    cmp("R9", {i_err, i_tgt, i_phys}, exp_i(16'h0040, m_lo, m_hi));

    // R3 window to instruction bank, R6 fetch through unified segments
    wr_map(2'd0, 16'h1005);
    wr_map(2'd1, 16'h0002);
    wr_map(2'd2, 16'h0007);
    sweep_strided();

    // R4 absent segment, R5/R6 mixed fetch maps
    wr_map(2'd0, 16'h03FF);
    wr_map(2'd1, 16'h1000);
    wr_map(2'd2, 16'h007F);
    sweep_strided();

    // R4 present segment 127 with sub-bank, R10 segment 1
    wr_map(2'd0, 16'h01FE);
    wr_map(2'd1, 16'h0001);
    wr_map(2'd2, 16'h10FF);
    sweep_strided();

    // R8: select 3 changes no map
    wr_map(2'd0, 16'h1003);
    wr_map(2'd1, 16'h1000);
    wr_map(2'd2, 16'h1000);
    map_we = 1'b1; map_sel = 2'd3; map_wdata = 16'h0003;
    @(posedge clk); #1;
    map_we = 1'b0;
    d_addr = 16'hA000; pc = 16'hF000;
    @(posedge clk); #1;
    cmp("R8", {d_err, d_tgt, d_phys}, exp_d(16'hA000, 16'h1003));
    cmp("R8", {i_err, i_tgt, i_phys}, exp_i(16'hF000, 16'h1000, 16'h1000));
    sweep_strided();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule